// File: doc/BRIEF.md
# ISA I/O Wait-State Generator

This block stretches ISA I/O cycles that target a two-port window, so that a slow agent behind the window has time to respond. When address enable is low, the upper nine port address bits hit the window and either the read or the write strobe is active, the block pulls its ready output low. It keeps ready low for a fixed number of bus clocks and then releases it, so the host can finish the transfer.

A terminal-count event marks the end of each wait. That event clears the counter so it is ready for the next access. A single strobe assertion produces exactly one wait. Accesses outside the window, and DMA cycles (address enable high), never see ready go low. The top level of the chip turns the `io_ready` output into an open-drain drive of the channel-ready line: low means the line is driven low, and high means it is released.

Top module: `isa_io_wait_gen`

## Requirements
- R1: While `bus_rst` is high, and on the first sample after it is released, `io_ready` is high. Reset acts asynchronously, even in the middle of a wait.
- R2: A wait starts only when `aen` is 0 and `io_addr[9:1]` equals `BASE_ADDR[9:1]`. With the default, that means ports 0x220 and 0x221. Ports 0x21F and 0x222, or `aen` at 1, leave `io_ready` high.
- R3: Either strobe starts a wait. The strobes are active low: `io_rd_n` = 0 or `io_wr_n` = 0.
- R4: On the first rising edge of `bus_clk` at which a decoded strobe is sampled, `io_ready` goes low. It stays low for exactly `WAIT_CLKS` clock periods and is high after the next edge.
- R5: The end of the count produces a one-clock terminal event. That event clears the counter, and the next separate access gets a full `WAIT_CLKS` wait.
- R6: A strobe held active after its wait has ended does not start a second wait. The strobe must be sampled inactive before a new wait can start.
- R7: If the decoded strobe is sampled inactive during a wait, `io_ready` is high after that edge, so no other cycle is stretched.
- R8: `WAIT_CLKS` is a parameter from 1 to 15 (default 5). Values outside that range stop elaboration. A value of 1 gives a single clock of wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | ISA bus clock; all state advances on its rising edge |
| bus_rst | input | 1 | Active-high system reset, asynchronous |
| aen | input | 1 | Address enable; high during DMA cycles, which are ignored |
| io_addr | input | ADDR_W (10) | ISA I/O port address |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| io_ready | output | 1 | Channel ready; low requests wait states |

## Verification
Each wrong internal state shows up on `io_ready` within one clock. A counter that is off by one lengthens or shortens the low window, which is visible on the edge where release was due. A counter that is not re-armed gives the next access a short wait, or no wait at all. A lost "already served" flag gives a second low window while the strobe is still held. A decode fault either stretches a neighbouring port or leaves the window unstretched from its first edge. The scoreboard compares `io_ready` on every clock, for both the default count and a count of one.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

  // True when the address selects the two-port window (bit 0 ignored)
  // and the cycle is not a DMA cycle.
  function automatic logic window_hit(input logic [9:0] addr,
                                      input logic       aen,
                                      input logic [9:0] base);
    return (!aen) && (addr[9:1] == base[9:1]);
  endfunction

  // Active-low strobes: either one marks an I/O access.
  function automatic logic strobe_on(input logic rd_n, input logic wr_n);
    return (!rd_n) || (!wr_n);
  endfunction

  // Terminal test of the wait counter: the last clock of the wait.
  function automatic logic at_terminal(input int unsigned cnt,
                                       input int unsigned wait_clks);
    return cnt == (wait_clks - 1);
  endfunction

endpackage

// File: rtl/isa_port_decode.sv
module isa_port_decode
  import isa_wait_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [9:0]  BASE_ADDR = 10'h220
) (
  input  logic              aen,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  output logic              hit_strobe
);
  logic [9:0] addr10;

  generate
    if (ADDR_W >= 10) begin : g_trim
      assign addr10 = io_addr[9:0];
    end else begin : g_pad
      assign addr10 = {{(10-ADDR_W){1'b0}}, io_addr};
    end
  endgenerate

  assign hit_strobe = window_hit(addr10, aen, BASE_ADDR) &&
                      strobe_on(io_rd_n, io_wr_n);
endmodule

// File: rtl/isa_wait_counter.sv
module isa_wait_counter
  import isa_wait_pkg::*;
#(
  parameter int unsigned WAIT_CLKS = 5,
  localparam int unsigned CNT_W = $clog2(WAIT_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  output logic             busy,
  output logic             spent,
  output logic             term,
  output logic [CNT_W-1:0] cnt
);
  // Terminal event: last clock of an active wait.
  assign term = busy && at_terminal(int'(cnt), WAIT_CLKS);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy  <= 1'b0;
      spent <= 1'b0;
      cnt   <= '0;
    end else if (!strobe) begin
      busy  <= 1'b0;
      spent <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      if (term) begin
        busy  <= 1'b0;
        spent <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (!spent) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end
endmodule

// File: rtl/isa_io_wait_gen.sv
module isa_io_wait_gen #(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [9:0]  BASE_ADDR = 10'h220,
  parameter int unsigned WAIT_CLKS = 5,
  localparam int unsigned CNT_W = $clog2(WAIT_CLKS + 1)
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              aen,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  output logic              io_ready
);
  generate
    if (WAIT_CLKS < 1 || WAIT_CLKS > 15) begin : g_bad_wait
      $error("WAIT_CLKS must lie in 1..15");
    end
  endgenerate

  // Internal events, named for the checker
  logic             hit_strobe;
  logic             wait_busy;
  logic             wait_spent;
  logic             wait_term;
  logic [CNT_W-1:0] wait_cnt;

  isa_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .aen        (aen),
    .io_addr    (io_addr),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n),
    .hit_strobe (hit_strobe)
  );

  isa_wait_counter #(.WAIT_CLKS(WAIT_CLKS)) u_cnt (
    .clk    (bus_clk),
    .rst    (bus_rst),
    .strobe (hit_strobe),
    .busy   (wait_busy),
    .spent  (wait_spent),
    .term   (wait_term),
    .cnt    (wait_cnt)
  );

  assign io_ready = !wait_busy;
endmodule

// File: rtl/isa_io_wait_gen_chk.sv
module isa_io_wait_gen_chk #(
  parameter int unsigned WAIT_CLKS = 5
) (
  input logic bus_clk,
  input logic bus_rst,
  input logic hit_strobe,
  input logic wait_spent,
  input logic wait_term,
  input logic io_ready
);
  logic [4:0] low_run;

  always_ff @(posedge bus_clk or posedge bus_rst) begin
    if (bus_rst)        low_run <= '0;
    else if (!io_ready) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  // R1: ready released while reset is applied
  always @(posedge bus_clk) begin
    if (bus_rst) assert_reset_ready_R1: assert (io_ready);
  end

  // R2/R7: ready low only after a decoded strobe was sampled
  assert_low_needs_hit_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !io_ready |-> $past(hit_strobe));

  // R4: low window never longer than the count
  assert_low_bounded_R4: assert property (@(posedge bus_clk) disable iff (bus_rst)
    low_run <= 5'(WAIT_CLKS));

  // R5: terminal event occurs only inside a wait and releases ready next
  assert_term_in_wait_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
    wait_term |-> !io_ready);
  assert_term_release_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
    wait_term |=> io_ready);

  // R6: a served strobe held active does not restart the wait
  assert_no_rewait_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (wait_spent && hit_strobe) |=> io_ready);
endmodule

bind isa_io_wait_gen isa_io_wait_gen_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (
  .bus_clk    (bus_clk),
  .bus_rst    (bus_rst),
  .hit_strobe (hit_strobe),
  .wait_spent (wait_spent),
  .wait_term  (wait_term),
  .io_ready   (io_ready)
);

// File: tb/isa_io_wait_gen_test.sv
module isa_io_wait_gen_test;
  localparam int unsigned W5 = 5;
  localparam int unsigned W1 = 1;

  logic       bus_clk = 1'b0;
  logic       bus_rst = 1'b1;
  logic       aen = 1'b0;
  logic [9:0] io_addr = 10'h000;
  logic       io_rd_n = 1'b1;
  logic       io_wr_n = 1'b1;
  logic       rdy5, rdy1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic  q_e5[$];
  logic  q_e1[$];
  string q_tag[$];

  always #2 bus_clk = ~bus_clk;  // 250 MHz

  isa_io_wait_gen #(.WAIT_CLKS(W5)) uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .aen(aen), .io_addr(io_addr),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_ready(rdy5));

  isa_io_wait_gen #(.WAIT_CLKS(W1)) uut_w1 (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .aen(aen), .io_addr(io_addr),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_ready(rdy1));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: io_ready=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge bus_clk);
      #1;
      if (q_tag.size() > 0) begin
        string t;
        logic e5, e1;
        t = q_tag.pop_front(); e5 = q_e5.pop_front(); e1 = q_e1.pop_front();
        check({t, " (wait 5)"}, rdy5, e5);
        check({t, " (wait 1)"}, rdy1, e1);
      end
    end
  end

  // Driver: one access held for 'hold' clocks, then one idle clock
  task automatic access(input logic [9:0] a, input logic a_en, input bit rd,
                        input int hold, input bit hit, input string tag);
    for (int i = 0; i < hold; i++) begin
      @(negedge bus_clk);
      io_addr = a; aen = a_en;
      io_rd_n = rd ? 1'b0 : 1'b1;
      io_wr_n = rd ? 1'b1 : 1'b0;
      q_e5.push_back(!(hit && i < int'(W5)));
      q_e1.push_back(!(hit && i < int'(W1)));
      q_tag.push_back(tag);
    end
    @(negedge bus_clk);
    io_rd_n = 1'b1; io_wr_n = 1'b1; aen = 1'b0;
    q_e5.push_back(1'b1); q_e1.push_back(1'b1); q_tag.push_back({tag, " release"});
  endtask

  task automatic drain();
    while (q_tag.size() > 0) @(negedge bus_clk);
    @(negedge bus_clk);
  endtask

  initial begin
    #1;
    check("R1 during reset", rdy5, 1'b1);
    check("R1 during reset", rdy1, 1'b1);
    repeat (3) @(negedge bus_clk);
    bus_rst = 1'b0;
    @(negedge bus_clk);
    check("R1 after reset", rdy5, 1'b1);

    access(10'h220, 1'b0, 1, 8, 1, "R4 read 0x220");
    access(10'h221, 1'b0, 0, 8, 1, "R3 write 0x221");
    access(10'h221, 1'b0, 1, 6, 1, "R5 rearm 0x221");
    access(10'h222, 1'b0, 1, 7, 0, "R2 miss 0x222");
    access(10'h21F, 1'b0, 0, 7, 0, "R2 miss 0x21F");
    access(10'h220, 1'b1, 1, 7, 0, "R2 aen high");
    access(10'h220, 1'b0, 0, 12, 1, "R6 held strobe");
    access(10'h220, 1'b0, 1, 2, 1, "R7 early drop");
    access(10'h221, 1'b0, 0, 5, 1, "R8 exact count");
    drain();

    // R1: asynchronous reset during a wait
    @(negedge bus_clk);
    io_addr = 10'h220; aen = 1'b0; io_rd_n = 1'b0;
    @(negedge bus_clk);
    @(negedge bus_clk);
    check("R1 wait active before reset", rdy5, 1'b0);
    bus_rst = 1'b1;
    #0.5;
    check("R1 async reset releases", rdy5, 1'b1);
    @(negedge bus_clk);
    io_rd_n = 1'b1;
    @(negedge bus_clk);
    bus_rst = 1'b0;
    @(negedge bus_clk);
    check("R1 idle after reset", rdy5, 1'b1);

    access(10'h220, 1'b0, 0, 7, 1, "R5 wait after reset");
    drain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule